// File: doc/BRIEF.md
# Multi-Harmonic Loop Phasing Rotator

This block turns the I/Q vectors of several harmonic servo loops by a per-harmonic angle. Each harmonic has two programmable angle terms: a phase offset and a delay-compensation term. Their modular sum sets the rotation angle. Angles are unsigned fractions of one full turn. One pipelined CORDIC turns these angles into cos/sin coefficients. It serves every harmonic in turn, one angle per clock, once per loop update. Each harmonic then has its own complex multiplier that rotates its vector by the stored coefficients. The result saturates to the signed I/Q width.

New coefficients fill a shadow bank. The whole active set is replaced in a single clock once the last harmonic is done, so the loops never run with a mix of old and new phasing. A small multiplexer also provides each harmonic's setpoint. The setpoint comes either from a constant or from one of several shared function channels, and a per-harmonic selector picks the channel.

Top module: `lprot_top`

## Requirements
- R1: While rst_ni is low, and until the first update completes after it, rot_i_o, rot_q_o, sp_i_o and sp_q_o read 0 during reset and coef_swap_o is 0. The active coefficient set is the zero angle, so each harmonic's output follows its input within 12 LSB.
- R2: Harmonic k occupies bits [k*W +: W] of every per-harmonic vector. Its rotation angle in turns is ((phase_off + dly_comp) mod 2^16) / 2^16. The output registered on the edge after an input is I*cos - Q*sin on rot_i_o and I*sin + Q*cos on rot_q_o, within 12 LSB.
- R3: A rotated component beyond the signed 16-bit range is clamped to 32767 or -32768. It never wraps.
- R4: When upd_i is sampled high while idle, coef_swap_o goes high for exactly one cycle. This happens after the (N_HARM + CORDIC_STAGES + 2)-th rising edge counted from the sampling edge, which is 20 edges with default parameters.
- R5: The rotators keep using the previous coefficient set up to and including the edge that raises coef_swap_o. On the following edge, every harmonic uses the new set.
- R6: upd_i sampled high while a coefficient update is in progress is ignored. It neither restarts nor adds a swap.
- R7: The angle sum wraps modulo 2^16. For example, an offset of 0xC000 plus a compensation of 0x8000 rotates by a quarter turn.
- R8: Each setpoint output is registered one cycle after its inputs. When sp_sel_i[k] is 0 it takes constant k. When sp_sel_i[k] is 1 it takes function channel sp_fsel_i[k*2 +: 2].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| upd_i | input | 1 | Loop update strobe, starts a coefficient refresh |
| phase_off_i | input | N_HARM*ANG_W | Per-harmonic phase offset, unsigned turn fraction |
| dly_comp_i | input | N_HARM*ANG_W | Per-harmonic delay-compensation angle |
| iq_i_i | input | N_HARM*IQ_W | In-phase input per harmonic, signed |
| iq_q_i | input | N_HARM*IQ_W | Quadrature input per harmonic, signed |
| rot_i_o | output | N_HARM*IQ_W | Rotated in-phase output per harmonic |
| rot_q_o | output | N_HARM*IQ_W | Rotated quadrature output per harmonic |
| coef_swap_o | output | 1 | One-cycle pulse when the new coefficient set takes over |
| sp_sel_i | input | N_HARM | Setpoint source per harmonic: 0 constant, 1 function channel |
| sp_fsel_i | input | N_HARM*FS_W | Function channel index per harmonic |
| sp_const_i_i | input | N_HARM*IQ_W | Constant setpoint, in-phase |
| sp_const_q_i | input | N_HARM*IQ_W | Constant setpoint, quadrature |
| func_i_i | input | N_FUNC*IQ_W | Function channels, in-phase |
| func_q_i | input | N_FUNC*IQ_W | Function channels, quadrature |
| sp_i_o | output | N_HARM*IQ_W | Selected setpoint, in-phase |
| sp_q_o | output | N_HARM*IQ_W | Selected setpoint, quadrature |

## Verification
The assertions assume that the angle terms stay constant from the update strobe until the last harmonic has been issued. They also assume that update strobes arrive either while idle or, when they are meant to be dropped, while a refresh is in progress. The stimulus writes new angles only before a strobe and leaves them alone until the swap pulse. Extra strobes are injected only inside that window. Random I/Q amplitudes stay below 20000 so that the tolerance checks measure CORDIC accuracy. Saturation is exercised only by directed full-scale vectors.

// File: rtl/lprot_pkg.sv
package lprot_pkg;
  // arctan(2^-i) in units of 2^-20 turn
  function automatic int atan_turn20(input int i);
    case (i)
      0:  return 131072;
      1:  return 77376;
      2:  return 40884;
      3:  return 20753;
      4:  return 10417;
      5:  return 5213;
      6:  return 2607;
      7:  return 1304;
      8:  return 652;
      9:  return 326;
      10: return 163;
      11: return 81;
      12: return 41;
      13: return 20;
      14: return 10;
      15: return 5;
      16: return 3;
      17: return 1;
      default: return 0;
    endcase
  endfunction
endpackage

// File: rtl/lprot_cordic.sv
module lprot_cordic #(
  parameter int ANG_W  = 16,
  parameter int OUT_W  = 16,
  parameter int STAGES = 14,
  parameter int TAG_W  = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    valid_i,
  input  logic [TAG_W-1:0]        tag_i,
  input  logic [ANG_W-1:0]        ang_i,
  output logic                    valid_o,
  output logic [TAG_W-1:0]        tag_o,
  output logic signed [OUT_W-1:0] cos_o,
  output logic signed [OUT_W-1:0] sin_o
);
  localparam int ZFRAC = 20;
  localparam int ZW    = ZFRAC + 1;
  localparam int GUARD = 4;
  localparam int XW    = OUT_W + 2 + GUARD;
  localparam int CMAX  = (1 << (OUT_W - 1)) - 1;
  localparam int X0    = (CMAX * 39797) >> (16 - GUARD); // 1/K gain pre-scale

  logic signed [XW-1:0] xs [STAGES+1];
  logic signed [XW-1:0] ys [STAGES+1];
  logic signed [ZW-1:0] zs [STAGES];
  logic                 vs [STAGES+1];
  logic [TAG_W-1:0]     ts [STAGES+1];
  logic signed [ZW-1:0] atan_c [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_atan
    assign atan_c[g] = ZW'(lprot_pkg::atan_turn20(g));
  end

  // fold angle into [-1/4, 1/4) turn, flip start vector when folded
  logic [ZFRAC-1:0] z_u, z_f;
  logic             flip;
  assign z_u  = ZFRAC'(ang_i) << (ZFRAC - ANG_W);
  assign flip = ang_i[ANG_W-1] ^ ang_i[ANG_W-2];
  assign z_f  = flip ? z_u - ZFRAC'(1 << (ZFRAC - 1)) : z_u;

  logic signed [XW-1:0] x_rnd, y_rnd, x_sh, y_sh;
  assign x_rnd = xs[STAGES] + XW'(1 << (GUARD - 1));
  assign y_rnd = ys[STAGES] + XW'(1 << (GUARD - 1));
  assign x_sh  = x_rnd >>> GUARD;
  assign y_sh  = y_rnd >>> GUARD;

  function automatic logic signed [OUT_W-1:0] clamp(input logic signed [XW-1:0] v);
    if (v > XW'(CMAX))       return OUT_W'(CMAX);
    else if (v < -XW'(CMAX)) return -OUT_W'(CMAX);
    else                     return v[OUT_W-1:0];
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i <= STAGES; i++) begin
        xs[i] <= '0;
        ys[i] <= '0;
        vs[i] <= 1'b0;
        ts[i] <= '0;
      end
      for (int i = 0; i < STAGES; i++) zs[i] <= '0;
      valid_o <= 1'b0;
      tag_o   <= '0;
      cos_o   <= '0;
      sin_o   <= '0;
    end else begin
      xs[0] <= flip ? -XW'(X0) : XW'(X0);
      ys[0] <= '0;
      zs[0] <= ZW'($signed(z_f));
      vs[0] <= valid_i;
      ts[0] <= tag_i;
      for (int i = 0; i < STAGES; i++) begin
        if (zs[i][ZW-1]) begin
          xs[i+1] <= xs[i] + (ys[i] >>> i);
          ys[i+1] <= ys[i] - (xs[i] >>> i);
          if (i < STAGES - 1) zs[i+1] <= zs[i] + atan_c[i];
        end else begin
          xs[i+1] <= xs[i] - (ys[i] >>> i);
          ys[i+1] <= ys[i] + (xs[i] >>> i);
          if (i < STAGES - 1) zs[i+1] <= zs[i] - atan_c[i];
        end
        vs[i+1] <= vs[i];
        ts[i+1] <= ts[i];
      end
      valid_o <= vs[STAGES];
      tag_o   <= ts[STAGES];
      cos_o   <= clamp(x_sh);
      sin_o   <= clamp(y_sh);
    end
  end
endmodule

// File: rtl/lprot_coef_seq.sv
module lprot_coef_seq #(
  parameter int N_HARM = 4,
  parameter int ANG_W  = 16,
  parameter int COEF_W = 16,
  parameter int STAGES = 14
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       upd_i,
  input  logic [N_HARM*ANG_W-1:0]    off_i,
  input  logic [N_HARM*ANG_W-1:0]    dly_i,
  output logic [N_HARM*COEF_W-1:0]   act_cos_o,
  output logic [N_HARM*COEF_W-1:0]   act_sin_o,
  output logic                       busy_o,
  output logic                       swap_o
);
  localparam int IDX_W = (N_HARM > 1) ? $clog2(N_HARM) : 1;
  localparam int CMAX  = (1 << (COEF_W - 1)) - 1;

  logic             issuing;
  logic [IDX_W-1:0] idx;
  logic [ANG_W-1:0] ang_sum;

  // modular sum of the two angle terms of the harmonic being issued
  assign ang_sum = off_i[idx*ANG_W +: ANG_W] + dly_i[idx*ANG_W +: ANG_W];

  logic                     c_valid;
  logic [IDX_W-1:0]         c_tag;
  logic signed [COEF_W-1:0] c_cos, c_sin;

  lprot_cordic #(
    .ANG_W (ANG_W),
    .OUT_W (COEF_W),
    .STAGES(STAGES),
    .TAG_W (IDX_W)
  ) i_cordic (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(issuing),
    .tag_i  (idx),
    .ang_i  (ang_sum),
    .valid_o(c_valid),
    .tag_o  (c_tag),
    .cos_o  (c_cos),
    .sin_o  (c_sin)
  );

  logic [N_HARM-1:0][COEF_W-1:0] sh_cos, sh_sin, act_cos, act_sin;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      issuing <= 1'b0;
      idx     <= '0;
      busy_o  <= 1'b0;
      swap_o  <= 1'b0;
      for (int k = 0; k < N_HARM; k++) begin
        sh_cos[k]  <= '0;
        sh_sin[k]  <= '0;
        act_cos[k] <= COEF_W'(CMAX);
        act_sin[k] <= '0;
      end
    end else begin
      swap_o <= 1'b0;
      if (upd_i && !busy_o) begin
        busy_o  <= 1'b1;
        issuing <= 1'b1;
        idx     <= '0;
      end else if (issuing) begin
        if (idx == IDX_W'(N_HARM - 1)) issuing <= 1'b0;
        idx <= idx + 1'b1;
      end
      if (c_valid) begin
        sh_cos[c_tag] <= c_cos;
        sh_sin[c_tag] <= c_sin;
        if (c_tag == IDX_W'(N_HARM - 1)) begin
          // last harmonic done: whole set goes live together
          for (int k = 0; k < N_HARM - 1; k++) begin
            act_cos[k] <= sh_cos[k];
            act_sin[k] <= sh_sin[k];
          end
          act_cos[N_HARM-1] <= c_cos;
          act_sin[N_HARM-1] <= c_sin;
          swap_o <= 1'b1;
          busy_o <= 1'b0;
        end
      end
    end
  end

  assign act_cos_o = act_cos;
  assign act_sin_o = act_sin;
endmodule

// File: rtl/lprot_cmul.sv
module lprot_cmul #(
  parameter int IQ_W   = 16,
  parameter int COEF_W = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic signed [IQ_W-1:0]   i_i,
  input  logic signed [IQ_W-1:0]   q_i,
  input  logic signed [COEF_W-1:0] c_i,
  input  logic signed [COEF_W-1:0] s_i,
  output logic signed [IQ_W-1:0]   i_o,
  output logic signed [IQ_W-1:0]   q_o
);
  localparam int PW = IQ_W + COEF_W + 1;
  localparam logic signed [PW-1:0] VMAX = PW'((1 << (IQ_W - 1)) - 1);
  localparam logic signed [PW-1:0] VMIN = -PW'(1 << (IQ_W - 1));

  logic signed [PW-1:0] ie, qe, ce, se, acc_i, acc_q, sh_i, sh_q;
  assign ie = PW'(i_i);
  assign qe = PW'(q_i);
  assign ce = PW'(c_i);
  assign se = PW'(s_i);
  assign acc_i = ie * ce - qe * se;
  assign acc_q = ie * se + qe * ce;
  assign sh_i  = acc_i >>> (COEF_W - 1);
  assign sh_q  = acc_q >>> (COEF_W - 1);

  function automatic logic signed [IQ_W-1:0] sat(input logic signed [PW-1:0] v);
    if (v > VMAX)      return IQ_W'(VMAX);
    else if (v < VMIN) return IQ_W'(VMIN);
    else               return v[IQ_W-1:0];
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      i_o <= '0;
      q_o <= '0;
    end else begin
      i_o <= sat(sh_i);
      q_o <= sat(sh_q);
    end
  end
endmodule

// File: rtl/lprot_sp_mux.sv
module lprot_sp_mux #(
  parameter int N_HARM = 4,
  parameter int IQ_W   = 16,
  parameter int N_FUNC = 4,
  parameter int FS_W   = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [N_HARM-1:0]        sel_i,
  input  logic [N_HARM*FS_W-1:0]   fsel_i,
  input  logic [N_HARM*IQ_W-1:0]   const_i_i,
  input  logic [N_HARM*IQ_W-1:0]   const_q_i,
  input  logic [N_FUNC*IQ_W-1:0]   func_i_i,
  input  logic [N_FUNC*IQ_W-1:0]   func_q_i,
  output logic [N_HARM*IQ_W-1:0]   sp_i_o,
  output logic [N_HARM*IQ_W-1:0]   sp_q_o
);
  localparam int NSLOT = 1 << FS_W;

  logic [IQ_W-1:0] fi [NSLOT];
  logic [IQ_W-1:0] fq [NSLOT];

  // unused channel slots read as zero
  for (genvar f = 0; f < NSLOT; f++) begin : g_slot
    if (f < N_FUNC) begin : g_real
      assign fi[f] = func_i_i[f*IQ_W +: IQ_W];
      assign fq[f] = func_q_i[f*IQ_W +: IQ_W];
    end else begin : g_pad
      assign fi[f] = '0;
      assign fq[f] = '0;
    end
  end

  for (genvar k = 0; k < N_HARM; k++) begin : g_sp
    logic [FS_W-1:0] ch;
    assign ch = fsel_i[k*FS_W +: FS_W];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sp_i_o[k*IQ_W +: IQ_W] <= '0;
        sp_q_o[k*IQ_W +: IQ_W] <= '0;
      end else if (sel_i[k]) begin
        sp_i_o[k*IQ_W +: IQ_W] <= fi[ch];
        sp_q_o[k*IQ_W +: IQ_W] <= fq[ch];
      end else begin
        sp_i_o[k*IQ_W +: IQ_W] <= const_i_i[k*IQ_W +: IQ_W];
        sp_q_o[k*IQ_W +: IQ_W] <= const_q_i[k*IQ_W +: IQ_W];
      end
    end
  end
endmodule

// File: rtl/lprot_top.sv
module lprot_top #(
  parameter int N_HARM        = 4,
  parameter int IQ_W          = 16,
  parameter int COEF_W        = 16,
  parameter int ANG_W         = 16,
  parameter int CORDIC_STAGES = 14,
  parameter int N_FUNC        = 4,
  localparam int FS_W         = (N_FUNC > 1) ? $clog2(N_FUNC) : 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     upd_i,
  input  logic [N_HARM*ANG_W-1:0]  phase_off_i,
  input  logic [N_HARM*ANG_W-1:0]  dly_comp_i,
  input  logic [N_HARM*IQ_W-1:0]   iq_i_i,
  input  logic [N_HARM*IQ_W-1:0]   iq_q_i,
  output logic [N_HARM*IQ_W-1:0]   rot_i_o,
  output logic [N_HARM*IQ_W-1:0]   rot_q_o,
  output logic                     coef_swap_o,
  input  logic [N_HARM-1:0]        sp_sel_i,
  input  logic [N_HARM*FS_W-1:0]   sp_fsel_i,
  input  logic [N_HARM*IQ_W-1:0]   sp_const_i_i,
  input  logic [N_HARM*IQ_W-1:0]   sp_const_q_i,
  input  logic [N_FUNC*IQ_W-1:0]   func_i_i,
  input  logic [N_FUNC*IQ_W-1:0]   func_q_i,
  output logic [N_HARM*IQ_W-1:0]   sp_i_o,
  output logic [N_HARM*IQ_W-1:0]   sp_q_o
);
  logic [N_HARM*COEF_W-1:0] act_cos, act_sin;
  logic                     upd_busy;

  lprot_coef_seq #(
    .N_HARM(N_HARM),
    .ANG_W (ANG_W),
    .COEF_W(COEF_W),
    .STAGES(CORDIC_STAGES)
  ) i_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .upd_i    (upd_i),
    .off_i    (phase_off_i),
    .dly_i    (dly_comp_i),
    .act_cos_o(act_cos),
    .act_sin_o(act_sin),
    .busy_o   (upd_busy),
    .swap_o   (coef_swap_o)
  );

  for (genvar k = 0; k < N_HARM; k++) begin : g_rot
    lprot_cmul #(
      .IQ_W  (IQ_W),
      .COEF_W(COEF_W)
    ) i_cmul (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .i_i   (iq_i_i[k*IQ_W +: IQ_W]),
      .q_i   (iq_q_i[k*IQ_W +: IQ_W]),
      .c_i   (act_cos[k*COEF_W +: COEF_W]),
      .s_i   (act_sin[k*COEF_W +: COEF_W]),
      .i_o   (rot_i_o[k*IQ_W +: IQ_W]),
      .q_o   (rot_q_o[k*IQ_W +: IQ_W])
    );
  end

  lprot_sp_mux #(
    .N_HARM(N_HARM),
    .IQ_W  (IQ_W),
    .N_FUNC(N_FUNC),
    .FS_W  (FS_W)
  ) i_sp (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sel_i    (sp_sel_i),
    .fsel_i   (sp_fsel_i),
    .const_i_i(sp_const_i_i),
    .const_q_i(sp_const_q_i),
    .func_i_i (func_i_i),
    .func_q_i (func_q_i),
    .sp_i_o   (sp_i_o),
    .sp_q_o   (sp_q_o)
  );
endmodule

// File: rtl/lprot_chk.sv
module lprot_chk #(
  parameter int N_HARM        = 4,
  parameter int IQ_W          = 16,
  parameter int COEF_W        = 16,
  parameter int CORDIC_STAGES = 14
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     upd_i,
  input logic                     busy_i,
  input logic                     swap_i,
  input logic [N_HARM*COEF_W-1:0] act_cos_i,
  input logic [N_HARM*COEF_W-1:0] act_sin_i,
  input logic                     sel0_i,
  input logic [IQ_W-1:0]          const0_i,
  input logic [IQ_W-1:0]          sp0_i,
  input logic [IQ_W-1:0]          in_i0_i,
  input logic [IQ_W-1:0]          in_q0_i,
  input logic [IQ_W-1:0]          rot_i0_i,
  input logic [IQ_W-1:0]          rot_q0_i
);
  localparam int LAT  = N_HARM + CORDIC_STAGES + 2;
  localparam int CMAX = (1 << (COEF_W - 1)) - 1;

  logic        past_ok, run;
  logic [15:0] cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      past_ok <= 1'b0;
      run     <= 1'b0;
      cnt     <= '0;
    end else begin
      past_ok <= 1'b1;
      if (upd_i && !busy_i) begin
        run <= 1'b1;
        cnt <= '0;
      end else if (run) begin
        cnt <= cnt + 16'd1;
        if (swap_i) run <= 1'b0;
      end
    end
  end

  p_reset_identity_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(past_ok) |-> act_cos_i[COEF_W-1:0] == COEF_W'(CMAX) && act_sin_i[COEF_W-1:0] == '0);

  p_zero_in_zero_out_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(in_i0_i == '0 && in_q0_i == '0) |-> rot_i0_i == '0 && rot_q0_i == '0);

  p_swap_latency_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swap_i |-> run && cnt == 16'(LAT));

  p_swap_single_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swap_i |=> !swap_i);

  p_coef_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && !swap_i |-> $stable(act_cos_i) && $stable(act_sin_i));

  p_busy_upd_ignored_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && upd_i |=> cnt == $past(cnt) + 16'd1);

  p_const_setpoint_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(!sel0_i) |-> sp0_i == $past(const0_i));
endmodule

bind lprot_top lprot_chk #(
  .N_HARM       (N_HARM),
  .IQ_W         (IQ_W),
  .COEF_W       (COEF_W),
  .CORDIC_STAGES(CORDIC_STAGES)
) i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .upd_i    (upd_i),
  .busy_i   (upd_busy),
  .swap_i   (coef_swap_o),
  .act_cos_i(act_cos),
  .act_sin_i(act_sin),
  .sel0_i   (sp_sel_i[0]),
  .const0_i (sp_const_i_i[IQ_W-1:0]),
  .sp0_i    (sp_i_o[IQ_W-1:0]),
  .in_i0_i  (iq_i_i[IQ_W-1:0]),
  .in_q0_i  (iq_q_i[IQ_W-1:0]),
  .rot_i0_i (rot_i_o[IQ_W-1:0]),
  .rot_q0_i (rot_q_o[IQ_W-1:0])
);

// File: tb/test_lprot_top.sv
`timescale 1ns/1ps
module test_lprot_top;
  localparam int N = 4, IQW = 16, AW = 16, S = 14, NF = 4, FSW = 2;
  localparam int LAT = N + S + 2;
  localparam int TOL = 12;

  logic clk = 1'b0, rst_n = 1'b0, upd = 1'b0;
  logic [N*AW-1:0]  off_v = '0, dly_v = '0;
  logic [N*IQW-1:0] iqi_v = '0, iqq_v = '0, ci_v = '0, cq_v = '0;
  logic [NF*IQW-1:0] fi_v = '0, fq_v = '0;
  logic [N-1:0]     sel_v = '0;
  logic [N*FSW-1:0] fsel_v = '0;
  logic [N*IQW-1:0] rot_i, rot_q, sp_i, sp_q;
  logic             swap;

  always #2.5 clk = ~clk;

  lprot_top i_lprot_top (
    .clk_i(clk), .rst_ni(rst_n), .upd_i(upd),
    .phase_off_i(off_v), .dly_comp_i(dly_v),
    .iq_i_i(iqi_v), .iq_q_i(iqq_v),
    .rot_i_o(rot_i), .rot_q_o(rot_q), .coef_swap_o(swap),
    .sp_sel_i(sel_v), .sp_fsel_i(fsel_v),
    .sp_const_i_i(ci_v), .sp_const_q_i(cq_v),
    .func_i_i(fi_v), .func_q_i(fq_v),
    .sp_i_o(sp_i), .sp_q_o(sp_q)
  );

  int n_chk = 0, n_fail = 0;
  int cur_ang [N];
  int old_ang [N];
  int in_i [N];
  int in_q [N];

  task automatic chk_eq(input string r, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", r, what, act, exp);
    end
  endtask

  task automatic chk_near(input string r, input string what, input int act, input int exp);
    int d;
    n_chk++;
    d = act - exp;
    if (d > TOL || d < -TOL) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", r, what, act, exp);
    end
  endtask

  function automatic int clamp16(input real v);
    if (v > 32767.0) return 32767;
    if (v < -32768.0) return -32768;
    return int'(v);
  endfunction

  function automatic int exp_rot(input int i, input int q, input int ang, input bit want_q);
    real th, c, s;
    th = 6.283185307179586 * real'(ang) / 65536.0;
    c = $cos(th);
    s = $sin(th);
    return want_q ? clamp16(i * s + q * c) : clamp16(i * c - q * s);
  endfunction

  task automatic set_angles(input int k, input int off, input int dly);
    off_v[k*AW +: AW] = AW'(off);
    dly_v[k*AW +: AW] = AW'(dly);
    cur_ang[k] = (off + dly) & 16'hFFFF;
  endtask

  task automatic set_iq(input int k, input int i, input int q);
    iqi_v[k*IQW +: IQW] = IQW'(i);
    iqq_v[k*IQW +: IQW] = IQW'(q);
    in_i[k] = i;
    in_q[k] = q;
  endtask

  task automatic chk_rot(input string r, input bit use_old);
    int a;
    for (int k = 0; k < N; k++) begin
      a = use_old ? old_ang[k] : cur_ang[k];
      chk_near(r, $sformatf("h%0d rot_i", k), int'($signed(rot_i[k*IQW +: IQW])),
               exp_rot(in_i[k], in_q[k], a, 1'b0));
      chk_near(r, $sformatf("h%0d rot_q", k), int'($signed(rot_q[k*IQW +: IQW])),
               exp_rot(in_i[k], in_q[k], a, 1'b1));
    end
  endtask

  // strobe update; optional extra strobe sampled at edge extra_at; optional mid-swap check
  task automatic run_update(input int extra_at, input bit mid_chk, output int lat, output int nsw);
    lat = -1;
    nsw = 0;
    @(negedge clk) upd = 1'b1;
    @(negedge clk) upd = 1'b0;
    for (int c = 1; c <= LAT + 30; c++) begin
      upd = (extra_at == c);
      @(negedge clk);
      if (swap) begin
        if (nsw == 0) lat = c;
        nsw++;
      end
      if (mid_chk && c == LAT) chk_rot("R5 old set through swap edge", 1'b1);
      if (mid_chk && c == LAT + 1) chk_rot("R5 new set after swap", 1'b0);
    end
    upd = 1'b0;
  endtask

  initial begin
    #(5ns * 150000);
    n_fail++;
    $display("FAIL R4 watchdog actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    int lat, nsw;
    void'($urandom(32'h5EED_0042));
    for (int k = 0; k < N; k++) begin
      set_angles(k, 0, 0);
      set_iq(k, 0, 0);
      old_ang[k] = 0;
    end
    set_iq(0, 1234, -567);
    repeat (3) @(negedge clk);
    // R1: reset state
    chk_eq("R1", "rot_i h0 in reset", int'($signed(rot_i[IQW-1:0])), 0);
    chk_eq("R1", "sp_i h0 in reset", int'($signed(sp_i[IQW-1:0])), 0);
    chk_eq("R1", "coef_swap_o in reset", int'(swap), 0);
    rst_n = 1'b1;
    for (int k = 0; k < N; k++) set_iq(k, 3000 * (k + 1), -2000 * k);
    @(negedge clk);
    chk_rot("R1 identity after reset", 1'b0);

    // R2/R5: random angles, update with mid-swap check
    for (int r = 0; r < 6; r++) begin
      for (int k = 0; k < N; k++) begin
        old_ang[k] = cur_ang[k];
        set_angles(k, int'($urandom_range(0, 65535)), int'($urandom_range(0, 65535)));
        set_iq(k, int'($urandom_range(0, 40000)) - 20000, int'($urandom_range(0, 40000)) - 20000);
      end
      run_update(0, 1'b1, lat, nsw);
      chk_eq("R4", "swap latency", lat, LAT);
      chk_eq("R4", "swap pulse count", nsw, 1);
      for (int v = 0; v < 3; v++) begin
        for (int k = 0; k < N; k++)
          set_iq(k, int'($urandom_range(0, 40000)) - 20000, int'($urandom_range(0, 40000)) - 20000);
        @(negedge clk);
        chk_rot("R2 random rotation", 1'b0);
      end
    end

    // R7: wrap of angle sum, quarter turn
    for (int k = 0; k < N; k++) begin
      set_angles(k, 16'hC000, 16'h8000);
      set_iq(k, 10000, 0);
    end
    run_update(0, 1'b0, lat, nsw);
    @(negedge clk);
    chk_eq("R7", "wrapped angle", cur_ang[0], 16'h4000);
    chk_rot("R7 wrap rotation", 1'b0);

    // R3: saturation at 45 degrees with full-scale vectors
    for (int k = 0; k < N; k++) set_angles(k, 16'h1000, 16'h1000);
    run_update(0, 1'b0, lat, nsw);
    set_iq(0, 32767, 32767);
    set_iq(1, -32768, -32768);
    @(negedge clk);
    chk_eq("R3", "h0 rot_q positive clamp", int'($signed(rot_q[0 +: IQW])), 32767);
    chk_eq("R3", "h1 rot_q negative clamp", int'($signed(rot_q[IQW +: IQW])), -32768);
    chk_near("R3", "h0 rot_i near zero", int'($signed(rot_i[0 +: IQW])), 0);

    // R6: strobes during a refresh are ignored
    for (int k = 0; k < N; k++) begin
      set_angles(k, 16'h0400 * (k + 1), 16'h0100);
      set_iq(k, 12000, -5000);
    end
    run_update(3, 1'b0, lat, nsw);
    chk_eq("R6", "latency with strobe at edge 3", lat, LAT);
    chk_eq("R6", "swaps with strobe at edge 3", nsw, 1);
    run_update(LAT - 1, 1'b0, lat, nsw);
    chk_eq("R6", "swaps with late strobe", nsw, 1);
    @(negedge clk);
    chk_rot("R6 coefficients after ignored strobes", 1'b0);

    // R8: setpoint selection
    for (int r = 0; r < 4; r++) begin
      sel_v = N'($urandom_range(0, (1 << N) - 1));
      fsel_v = (N*FSW)'($urandom);
      ci_v = (N*IQW)'({$urandom, $urandom});
      cq_v = (N*IQW)'({$urandom, $urandom});
      fi_v = (NF*IQW)'({$urandom, $urandom});
      fq_v = (NF*IQW)'({$urandom, $urandom});
      if (r == 0) sel_v = '0;
      if (r == 1) sel_v = '1;
      @(negedge clk);
      for (int k = 0; k < N; k++) begin
        int ch;
        int ei, eq;
        ch = int'(fsel_v[k*FSW +: FSW]);
        ei = sel_v[k] ? int'(fi_v[ch*IQW +: IQW]) : int'(ci_v[k*IQW +: IQW]);
        eq = sel_v[k] ? int'(fq_v[ch*IQW +: IQW]) : int'(cq_v[k*IQW +: IQW]);
        chk_eq("R8", $sformatf("h%0d sp_i", k), int'(sp_i[k*IQW +: IQW]), ei);
        chk_eq("R8", $sformatf("h%0d sp_q", k), int'(sp_q[k*IQW +: IQW]), eq);
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule